// File: doc/BRIEF.md
# Serial command/response slave with selectable read pin

This block is the bus-facing end of a peripheral that takes commands and returns responses over a four-signal serial link: a clock, a data input line, an active-low select and two possible data-out paths. Each transaction opens when select falls. The first eight bits, most significant bit first, form a control byte. Exactly five control values are legal. One writes an eight-byte command (an opcode followed by seven arguments). The other four read either a single status byte or a sixteen-byte response, whose first byte is the status. The read goes out on the main data line or on an alternate output pin.

The serial inputs are synchronised into the system clock domain and their edges are detected there. Incoming command bytes fill a command buffer, and a full eight-byte write raises a one-cycle strobe. Read data is taken bit by bit from a response vector that the host side holds. Each new bit is presented after a falling serial clock edge, so the master can sample it on the following rising edge. Raising select ends the transaction at any point. A control byte outside the legal set makes the slave ignore the rest of the transaction.

Top module: `spi_cmdresp_slave`

## Requirements
- R1: After reset both output enables and `cmd_valid` are low, and the data outputs are low.
- R2: After select falls, the slave collects a control byte on eight rising serial clock edges, most significant bit first.
- R3: Control byte 0x48 accepts exactly eight further bytes, captured MSB first on rising edges. Byte k is placed at `cmd_bytes[8k+7:8k]`, and after the eighth byte `cmd_valid` pulses high for exactly one clock.
- R4: Control byte 0x80 sends one byte (response byte 0, the status) on `spi_dout`. Control byte 0xA0 sends the same byte on `alt_dout`.
- R5: Control byte 0xC0 sends sixteen bytes on `spi_dout`, and 0xE0 sends them on `alt_dout`. The bytes go out in the order 0 to 15, with byte j taken from `resp_bytes[8j+7:8j]`, MSB first.
- R6: Read data changes only after a falling serial clock edge. The first data bit appears after the first falling edge that follows the control byte, and it holds through the following rising edge.
- R7: During a read only the chosen pin's enable is ever high. The two enables are never high together.
- R8: Any other control byte (for example 0x55 or 0x49) keeps both enables low and produces no `cmd_valid` until select rises.
- R9: Raising select aborts any transfer. Both enables drop within four clocks, and a write cut short before its eighth byte produces no `cmd_valid`.
- R10: After the last bit of a read, the next falling serial clock edge drops the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sel_n | input | 1 | Active-low transaction select |
| spi_din | input | 1 | Serial data from the master |
| spi_dout | output | 1 | Read data on the main line |
| spi_dout_oe | output | 1 | Drive enable for the main line |
| alt_dout | output | 1 | Read data on the alternate pin |
| alt_dout_oe | output | 1 | Drive enable for the alternate pin |
| resp_bytes | input | 128 | Response buffer, byte j at bits [8j+7:8j] |
| cmd_bytes | output | 64 | Received command, byte k at bits [8k+7:8k] |
| cmd_valid | output | 1 | One-clock strobe when a full command has arrived |

## Verification
The assertions assume that the serial clock and select are slow compared with `clk`. Each level of the serial clock must last at least four system clocks, so that the two-stage synchroniser and the edge register see every edge as a single-cycle event. They also assume that the response vector stays still while a read is in progress. The bench changes every serial input on the falling system clock edge and holds each serial clock phase for eight clocks. It sets the response vector once before any read, so the stimulus stays inside these assumptions.

// File: rtl/spi_cr_pkg.sv
package spi_cr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WRITE,
        ST_READ,
        ST_IGNORE,
        ST_DONE
    } cr_state_e;

    localparam logic [7:0] OP_CMD_WRITE  = 8'h48;
    localparam logic [7:0] OP_RD1_MAIN   = 8'h80;
    localparam logic [7:0] OP_RD16_MAIN  = 8'hC0;
    localparam logic [7:0] OP_RD1_ALT    = 8'hA0;
    localparam logic [7:0] OP_RD16_ALT   = 8'hE0;

    typedef struct packed {
        logic legal;
        logic is_write;
        logic long_read;
        logic alt_pin;
    } op_decode_s;

    function automatic op_decode_s decode_ctrl(input logic [7:0] code);
        op_decode_s r;
        r = '0;
        case (code)
            OP_CMD_WRITE: begin r.legal = 1'b1; r.is_write = 1'b1; end
            OP_RD1_MAIN:  begin r.legal = 1'b1; end
            OP_RD16_MAIN: begin r.legal = 1'b1; r.long_read = 1'b1; end
            OP_RD1_ALT:   begin r.legal = 1'b1; r.alt_pin = 1'b1; end
            OP_RD16_ALT:  begin r.legal = 1'b1; r.long_read = 1'b1; r.alt_pin = 1'b1; end
            default:      r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_cr_sync.sv
module spi_cr_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [2:0] RST_VAL = 3'b000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL[WIDTH-1:0];
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/spi_cr_cmdbuf.sv
module spi_cr_cmdbuf #(
    parameter int NBYTES = 8,
    localparam int IDXW  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_byte,
    input  logic                  wr_last,
    output logic [NBYTES*8-1:0]   cmd_bytes,
    output logic                  cmd_valid
);

    typedef struct packed {
        logic [NBYTES-1:0][7:0] bytes;
        logic                   valid;
    } buf_s;

    buf_s buf_d, buf_q;

    always_comb begin
        buf_d       = buf_q;
        buf_d.valid = 1'b0;
        if (wr_en) begin
            buf_d.bytes[wr_idx] = wr_byte;
            buf_d.valid         = wr_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign cmd_bytes = buf_q.bytes;
    assign cmd_valid = buf_q.valid;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R3

endmodule

// File: rtl/spi_cr_fsm.sv
module spi_cr_fsm
    import spi_cr_pkg::*;
#(
    parameter int CMD_BYTES  = 8,
    parameter int RESP_BYTES = 16,
    localparam int RESP_BITS = RESP_BYTES * 8,
    localparam int IW        = $clog2(RESP_BITS + 1),
    localparam int BW        = $clog2(RESP_BITS),
    localparam int CW        = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_s,
    input  logic                 sel_hi,
    input  logic                 din_s,
    input  logic [RESP_BITS-1:0] resp_bytes,
    output logic                 byte_wr,
    output logic [CW-1:0]        byte_idx,
    output logic [7:0]           byte_val,
    output logic                 cmd_done,
    output logic                 main_out,
    output logic                 main_oe,
    output logic                 alt_out,
    output logic                 alt_oe
);

    typedef struct packed {
        cr_state_e      st;
        logic [7:0]     sh;
        logic [2:0]     bitc;
        logic [IW-1:0]  idx;
        logic           rd_long;
        logic           rd_alt;
        logic           drv;
        logic           dout;
        logic           sclk_prev;
    } fsm_s;

    fsm_s f_d, f_q;

    logic          rise, fall;
    logic [7:0]    byte_now;
    logic [IW-1:0] total_bits;
    logic [BW-1:0] bit_pos;
    op_decode_s    op;

    assign rise       = sclk_s & ~f_q.sclk_prev;
    assign fall       = ~sclk_s & f_q.sclk_prev;
    assign byte_now   = {f_q.sh[6:0], din_s};
    assign total_bits = f_q.rd_long ? IW'(RESP_BITS) : IW'(8);
    assign bit_pos    = BW'({f_q.idx[IW-1:3], ~f_q.idx[2:0]});
    assign op         = decode_ctrl(byte_now);

    always_comb begin
        f_d           = f_q;
        f_d.sclk_prev = sclk_s;
        byte_wr       = 1'b0;
        byte_val      = byte_now;
        cmd_done      = 1'b0;
        if (sel_hi) begin
            f_d.st   = ST_IDLE;
            f_d.bitc = '0;
            f_d.idx  = '0;
            f_d.drv  = 1'b0;
        end else begin
            case (f_q.st)
                ST_IDLE, ST_CTRL: begin
                    f_d.st = ST_CTRL;
                    if (rise) begin
                        f_d.sh   = byte_now;
                        f_d.bitc = f_q.bitc + 3'd1;
                        if (f_q.bitc == 3'd7) begin
                            f_d.idx     = '0;
                            f_d.rd_long = op.long_read;
                            f_d.rd_alt  = op.alt_pin;
                            if (!op.legal)        f_d.st = ST_IGNORE;
                            else if (op.is_write) f_d.st = ST_WRITE;
                            else                  f_d.st = ST_READ;
                        end
                    end
                end
                ST_WRITE: begin
                    if (rise) begin
                        f_d.sh   = byte_now;
                        f_d.bitc = f_q.bitc + 3'd1;
                        if (f_q.bitc == 3'd7) begin
                            byte_wr = 1'b1;
                            if (f_q.idx == IW'(CMD_BYTES - 1)) begin
                                cmd_done = 1'b1;
                                f_d.st   = ST_DONE;
                            end else begin
                                f_d.idx = f_q.idx + IW'(1);
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (fall) begin
                        if (f_q.idx == total_bits) begin
                            f_d.drv = 1'b0;
                            f_d.st  = ST_DONE;
                        end else begin
                            f_d.drv  = 1'b1;
                            f_d.dout = resp_bytes[bit_pos];
                            f_d.idx  = f_q.idx + IW'(1);
                        end
                    end
                end
                default: begin
                    f_d.drv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign byte_idx = f_q.idx[CW-1:0];
    assign main_oe  = (f_q.st == ST_READ) && f_q.drv && !f_q.rd_alt;
    assign alt_oe   = (f_q.st == ST_READ) && f_q.drv && f_q.rd_alt;
    assign main_out = main_oe & f_q.dout;
    assign alt_out  = alt_oe & f_q.dout;

    AST_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        !(main_oe && alt_oe)); // R7
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> (!main_oe && !alt_oe)); // R9
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$past(fall) |-> $stable(f_q.dout)); // R6
    AST_OE_RISE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(main_oe || alt_oe) |-> $past(fall)); // R6
    AST_OE_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(main_oe || alt_oe) |-> $past(fall || sel_hi)); // R10

endmodule

// File: rtl/spi_cmdresp_slave.sv
module spi_cmdresp_slave
    import spi_cr_pkg::*;
#(
    parameter int CMD_BYTES   = 8,
    parameter int RESP_BYTES  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sclk,
    input  logic                    spi_sel_n,
    input  logic                    spi_din,
    output logic                    spi_dout,
    output logic                    spi_dout_oe,
    output logic                    alt_dout,
    output logic                    alt_dout_oe,
    input  logic [RESP_BYTES*8-1:0] resp_bytes,
    output logic [CMD_BYTES*8-1:0]  cmd_bytes,
    output logic                    cmd_valid
);

    logic [2:0]    sync_v;
    logic          byte_wr, cmd_done;
    logic [CW-1:0] byte_idx;
    logic [7:0]    byte_val;

    spi_cr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({spi_din, spi_sel_n, spi_sclk}),
        .sync_out (sync_v)
    );

    spi_cr_fsm #(
        .CMD_BYTES  (CMD_BYTES),
        .RESP_BYTES (RESP_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sync_v[0]),
        .sel_hi     (sync_v[1]),
        .din_s      (sync_v[2]),
        .resp_bytes (resp_bytes),
        .byte_wr    (byte_wr),
        .byte_idx   (byte_idx),
        .byte_val   (byte_val),
        .cmd_done   (cmd_done),
        .main_out   (spi_dout),
        .main_oe    (spi_dout_oe),
        .alt_out    (alt_dout),
        .alt_oe     (alt_dout_oe)
    );

    spi_cr_cmdbuf #(
        .NBYTES (CMD_BYTES)
    ) u_cmdbuf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (byte_wr),
        .wr_idx    (byte_idx),
        .wr_byte   (byte_val),
        .wr_last   (cmd_done),
        .cmd_bytes (cmd_bytes),
        .cmd_valid (cmd_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!spi_dout_oe && !alt_dout_oe && !cmd_valid)); // R1
    AST_VALID_SELECTED: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(sync_v[1])); // R9

endmodule

// File: tb/sim_spi_cmdresp_slave.sv
`timescale 1ns/1ps
module sim_spi_cmdresp_slave;

    localparam int H = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         spi_sclk = 1'b0;
    logic         spi_sel_n = 1'b1;
    logic         spi_din = 1'b0;
    logic         spi_dout, spi_dout_oe, alt_dout, alt_dout_oe;
    logic [127:0] resp_bytes;
    logic [63:0]  cmd_bytes;
    logic         cmd_valid;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    int both_on = 0;
    bit seen_main = 0;
    bit seen_alt  = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_cmdresp_slave u0 (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_sel_n(spi_sel_n),
        .spi_din(spi_din), .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe),
        .alt_dout(alt_dout), .alt_dout_oe(alt_dout_oe), .resp_bytes(resp_bytes),
        .cmd_bytes(cmd_bytes), .cmd_valid(cmd_valid)
    );

    // per-clock monitor of the reference expectations
    always @(posedge clk) begin
        if (!rst) begin
            if (cmd_valid) vcount++;
            if (spi_dout_oe) seen_main = 1;
            if (alt_dout_oe) seen_alt = 1;
            if (spi_dout_oe && alt_dout_oe) both_on++;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_txn();
        seen_main = 0; seen_alt = 0;
        spi_sclk = 1'b0;
        spi_sel_n = 1'b0;
        wclk(H);
    endtask

    task automatic close_txn();
        spi_sel_n = 1'b1;
        wclk(2 * H);
    endtask

    // one bit period: fall, low phase, sample, rise, high phase, sample
    task automatic bit_cycle(input logic b, output logic [3:0] s_lo, output logic [3:0] s_hi);
        spi_sclk = 1'b0;
        spi_din  = b;
        wclk(H);
        s_lo = {spi_dout_oe, spi_dout, alt_dout_oe, alt_dout};
        spi_sclk = 1'b1;
        wclk(H);
        s_hi = {spi_dout_oe, spi_dout, alt_dout_oe, alt_dout};
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [3:0] a, c;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], a, c);
    endtask

    task automatic read_txn(input logic [7:0] code, input int nbytes, input bit alt,
                            input string req);
        logic [3:0] lo, hi;
        bit q[$];
        int errs = 0;
        open_txn();
        send_byte(code);
        for (int j = 0; j < nbytes; j++)
            for (int i = 7; i >= 0; i--) q.push_back(resp_bytes[8*j+i]);
        while (q.size() > 0) begin
            bit e;
            e = q.pop_front();
            bit_cycle(1'b0, lo, hi);
            if (alt) begin
                if (lo !== {2'b00, 1'b1, e}) errs++;
            end else begin
                if (lo !== {1'b1, e, 2'b00}) errs++;
            end
            if (hi !== lo) errs++;     // R6: held through rising edge
        end
        chk({req, " read data/enable"}, errs, 0);
        chk("R6 value held across rise", hi, lo);
        bit_cycle(1'b0, lo, hi);
        chk("R10 enable released after last bit", {lo[3], lo[1]}, 2'b00);
        chk("R7 unselected pin never enabled", alt ? seen_main : seen_alt, 1'b0);
        close_txn();
    endtask

    initial begin
        for (int j = 0; j < 16; j++) resp_bytes[8*j +: 8] = 8'(8'h3C ^ (j * 37));
        wclk(5);
        rst = 1'b0;
        wclk(3);
        chk("R1 reset enables", {spi_dout_oe, alt_dout_oe}, 2'b00);
        chk("R1 reset valid/data", {cmd_valid, spi_dout, alt_dout}, 3'b000);

        begin : wr_full
            logic [63:0] exp;
            int v0;
            v0 = vcount;
            open_txn();
            send_byte(8'h48);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] b;
                b = 8'(8'hA1 + k * 19);
                exp[8*k +: 8] = b;
                send_byte(b);
            end
            close_txn();
            chk("R3 command bytes", cmd_bytes, exp);
            chk("R3 single valid strobe", vcount - v0, 1);
            chk("R3 no enables during write", {seen_main, seen_alt}, 2'b00);
        end

        begin : wr_abort
            int v0;
            v0 = vcount;
            open_txn();
            send_byte(8'h48);
            send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
            close_txn();
            chk("R9 aborted write has no strobe", vcount - v0, 0);
        end

        read_txn(8'h80, 1, 1'b0, "R2 R4 status main");
        read_txn(8'hA0, 1, 1'b1, "R4 status alt");
        read_txn(8'hC0, 16, 1'b0, "R5 long main");
        read_txn(8'hE0, 16, 1'b1, "R5 long alt");

        begin : bad_codes
            logic [7:0] codes [2];
            codes[0] = 8'h55; codes[1] = 8'h49;
            foreach (codes[c]) begin
                int v0;
                v0 = vcount;
                open_txn();
                send_byte(codes[c]);
                send_byte(8'hFF); send_byte(8'h00);
                close_txn();
                chk("R8 illegal code no enables", {seen_main, seen_alt}, 2'b00);
                chk("R8 illegal code no strobe", vcount - v0, 0);
            end
        end

        begin : rd_abort
            logic [3:0] lo, hi;
            open_txn();
            send_byte(8'hC0);
            for (int i = 0; i < 5; i++) bit_cycle(1'b0, lo, hi);
            chk("R9 enable on before abort", lo[3], 1'b1);
            spi_sel_n = 1'b1;
            wclk(5);
            chk("R9 abort drops enables", {spi_dout_oe, alt_dout_oe}, 2'b00);
            wclk(2 * H);
        end

        read_txn(8'h80, 1, 1'b0, "R9 clean read after abort");
        chk("R7 enables never both high", both_on, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule